// File: doc/BRIEF.md
# Free-Running Timer with Compare and Capture

This block is a 16-bit up-counter driven by a programmable clock prescaler. It watches the counter with four compare channels and four capture channels. A compare channel raises a flag and moves a waveform output when the counter leaves the value held in its compare register. A capture channel samples the counter on a selected edge of its input pin and raises a flag. The counter also raises a flag when it wraps. Compare channel 0 can be set up to bound the counting period, so that the counter returns to zero instead of advancing.

Compare channels are grouped in pairs (0,1) and (2,3). In single mode each channel toggles its own output. In paired mode the two registers of a pair jointly shape one pulse on the even output. The interrupt line is the OR of all sticky flags. Software configures the block and reads it back over a simple synchronous register port. Writes take effect at the clock edge. Reads are combinational from the address.

Register addresses: 0 control, 1 counter, 2..5 compare 0..3, 6..9 capture 0..3 (read-only), 10 edge select, 11 flags.

Top module: `ftc_timer`

## Requirements
- R1: After reset the counter, the compare and capture registers, the flags, all waveform outputs and `irqReq` read zero.
- R2: Control bits [2:0] select a prescale of 2^(sel+1), from 2 up to 256, and bit 3 enables counting. While counting, the counter advances once every 2^(sel+1) clocks. The first increment lands 2^(sel+1) clocks after the edge that enabled it. While counting is disabled the counter holds its value. A write to address 1 loads the counter.
- R3: When the counter leaves 0xFFFF it becomes 0 and flag bit 8 is set on that same edge.
- R4: When the counter leaves a value equal to compare register i, flag bit i is set on that edge.
- R5: With control bit 4 set, a match on compare channel 0 loads zero instead of incrementing, which gives a period of cmp0+1 counts.
- R6: In single mode a match on channel i toggles `waveOut[i]` on the same edge as the flag.
- R7: With control bit 5 (pair 0,1) or bit 6 (pair 2,3) set, a match on the even channel drives the even output high and a match on the odd channel drives it low. The odd output of that pair stays low.
- R8: Edge-select bits [2c+1:2c] configure capture channel c. Code 01 selects rising edges, 10 falling edges, 11 both, and 00 none. An edge that is not selected leaves the capture register and flag bit 4+c unchanged.
- R9: A capture input passes through two synchroniser flops. The capture register and flag bit 4+c update on the third rising clock edge after the pin changes, and the register takes the counter value held at that time.
- R10: Flags are sticky. A write to address 11 clears every flag whose data bit is 0 and keeps every flag whose data bit is 1. An event in the same cycle as the write wins.
- R11: `irqReq` is high exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 4 | Register address |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr` |
| capIn | input | 4 | Capture input pins |
| waveOut | output | 4 | Compare waveform outputs |
| irqReq | output | 1 | OR of all flags |

## Verification
A prescaler that is off by one shifts every counter readback and every waveform edge by a whole number of counts. With the fastest prescale this shows within a few clocks. A mismatch in compare or clear-on-match logic shows on the flag or output at the exact edge the counter leaves the matching value. It also shows as a counter value above the bound at the next readback. Synchroniser or edge-decode errors move the capture flag off its third-edge slot, or store a value when an unselected edge arrives. The bench samples these one cycle before and on the expected edge.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int CNT_W   = 16;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 4;
  localparam int N_CMP   = 4;
  localparam int N_CAP   = 4;
  localparam int N_PAIR  = N_CMP / 2;
  localparam int PSEL_W  = 3;
  localparam int PRESC_W = 1 << PSEL_W;
  localparam int FLAG_W  = N_CMP + N_CAP + 1;
  localparam int CTRL_W  = PSEL_W + 2 + N_PAIR;
  localparam int EDGE_W  = 2 * N_CAP;

  localparam int A_CTRL  = 0;
  localparam int A_COUNT = 1;
  localparam int A_CMP0  = 2;
  localparam int A_CAP0  = A_CMP0 + N_CMP;
  localparam int A_EDGE  = A_CAP0 + N_CAP;
  localparam int A_FLAG  = A_EDGE + 1;

  typedef struct packed {
    logic                run;
    logic [PSEL_W-1:0]   presSel;
    logic                clrOnMatch;
    logic [N_PAIR-1:0]   pairMode;
    logic                loadCount;
    logic [N_CMP-1:0]    loadCmp;
    logic [CNT_W-1:0]    wrValue;
    logic [EDGE_W-1:0]   edgeSel;
  } ftcStrobe_t;

  typedef struct packed {
    logic [N_CMP-1:0] cmpHit;
    logic [N_CAP-1:0] capHit;
    logic             ovf;
  } ftcEvent_t;
endpackage

// File: rtl/ftc_datapath.sv
module ftc_datapath
  import ftc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  ftcStrobe_t                   strobe,
  input  logic [N_CAP-1:0]             capIn,
  output logic [CNT_W-1:0]             count,
  output logic [N_CMP-1:0][CNT_W-1:0]  cmpVal,
  output logic [N_CAP-1:0][CNT_W-1:0]  capVal,
  output logic [N_CMP-1:0]             waveOut,
  output ftcEvent_t                    events
);
  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] prescLim;
  logic               tick;

  assign prescLim = PRESC_W'((2 << strobe.presSel) - 1);
  assign tick     = strobe.run && (prescCnt >= prescLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    prescCnt <= '0;
    else if (!strobe.run || tick) prescCnt <= '0;
    else                          prescCnt <= prescCnt + 1'b1;
  end

  // compare match events: counter leaves the matching value on a tick
  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    assign events.cmpHit[i] = tick && (count == cmpVal[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  cmpVal[i] <= '0;
      else if (strobe.loadCmp[i]) cmpVal[i] <= strobe.wrValue;
    end
  end

  assign events.ovf = tick && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (strobe.loadCount) count <= strobe.wrValue;
    else if (tick) begin
      if (strobe.clrOnMatch && events.cmpHit[0]) count <= '0;
      else                                       count <= count + 1'b1;
    end
  end

  // waveform outputs, one generate per compare pair
  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    localparam int EV = 2 * p;
    localparam int OD = 2 * p + 1;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        waveOut[EV] <= 1'b0;
        waveOut[OD] <= 1'b0;
      end else if (strobe.pairMode[p]) begin
        if (events.cmpHit[OD])      waveOut[EV] <= 1'b0;
        else if (events.cmpHit[EV]) waveOut[EV] <= 1'b1;
        waveOut[OD] <= 1'b0;
      end else begin
        if (events.cmpHit[EV]) waveOut[EV] <= ~waveOut[EV];
        if (events.cmpHit[OD]) waveOut[OD] <= ~waveOut[OD];
      end
    end

    assert_pair_odd_low_R7: assert property (@(posedge clk) disable iff (!rstN)
      strobe.pairMode[p] |=> !waveOut[OD]);
  end

  // capture path: two-flop synchroniser plus one history flop
  logic [N_CAP-1:0] syncA, syncB, syncPrev;
  logic [N_CAP-1:0] riseEdge, fallEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= capIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign riseEdge = syncB & ~syncPrev;
  assign fallEdge = ~syncB & syncPrev;

  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    assign events.capHit[c] = (strobe.edgeSel[2*c]   && riseEdge[c]) ||
                              (strobe.edgeSel[2*c+1] && fallEdge[c]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  capVal[c] <= '0;
      else if (events.capHit[c])  capVal[c] <= count;
    end
  end

  assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.loadCount) |=> count == $past(count));

  assert_count_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && count == {CNT_W{1'b1}} && !strobe.loadCount) |=> count == '0);

  assert_cap_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    events.capHit[0] |=> capVal[0] == $past(count));
endmodule

// File: rtl/ftc_ctrl.sv
module ftc_ctrl
  import ftc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busWr,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWrData,
  output logic [DATA_W-1:0]            busRdData,
  input  logic [CNT_W-1:0]             count,
  input  logic [N_CMP-1:0][CNT_W-1:0]  cmpVal,
  input  logic [N_CAP-1:0][CNT_W-1:0]  capVal,
  input  ftcEvent_t                    events,
  output ftcStrobe_t                   strobe,
  output logic                         irqReq
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [EDGE_W-1:0] edgeReg;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] eventVec;
  logic wrCtrl, wrEdge, wrFlag;

  assign wrCtrl = busWr && (busAddr == ADDR_W'(A_CTRL));
  assign wrEdge = busWr && (busAddr == ADDR_W'(A_EDGE));
  assign wrFlag = busWr && (busAddr == ADDR_W'(A_FLAG));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      edgeReg <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= busWrData[CTRL_W-1:0];
      if (wrEdge) edgeReg <= busWrData[EDGE_W-1:0];
    end
  end

  assign eventVec = {events.ovf, events.capHit, events.cmpHit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (wrFlag ? (flags & busWrData[FLAG_W-1:0]) : flags) | eventVec;
  end

  assign irqReq = |flags;

  always_comb begin
    strobe            = '0;
    strobe.presSel    = ctrlReg[PSEL_W-1:0];
    strobe.run        = ctrlReg[PSEL_W];
    strobe.clrOnMatch = ctrlReg[PSEL_W+1];
    strobe.pairMode   = ctrlReg[PSEL_W+2 +: N_PAIR];
    strobe.loadCount  = busWr && (busAddr == ADDR_W'(A_COUNT));
    strobe.wrValue    = busWrData[CNT_W-1:0];
    strobe.edgeSel    = edgeReg;
    for (int i = 0; i < N_CMP; i++)
      strobe.loadCmp[i] = busWr && (busAddr == ADDR_W'(A_CMP0 + i));
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(A_CTRL))  busRdData = DATA_W'(ctrlReg);
    if (busAddr == ADDR_W'(A_COUNT)) busRdData = DATA_W'(count);
    if (busAddr == ADDR_W'(A_EDGE))  busRdData = DATA_W'(edgeReg);
    if (busAddr == ADDR_W'(A_FLAG))  busRdData = DATA_W'(flags);
    for (int i = 0; i < N_CMP; i++)
      if (busAddr == ADDR_W'(A_CMP0 + i)) busRdData = DATA_W'(cmpVal[i]);
    for (int i = 0; i < N_CAP; i++)
      if (busAddr == ADDR_W'(A_CAP0 + i)) busRdData = DATA_W'(capVal[i]);
  end

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flags[FLAG_W-1] && !wrFlag) |=> flags[FLAG_W-1]);

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|eventVec) |=> irqReq);
endmodule

// File: rtl/ftc_timer.sv
module ftc_timer
  import ftc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [N_CAP-1:0]  capIn,
  output logic [N_CMP-1:0]  waveOut,
  output logic              irqReq
);
  ftcStrobe_t                  strobe;
  ftcEvent_t                   events;
  logic [CNT_W-1:0]            count;
  logic [N_CMP-1:0][CNT_W-1:0] cmpVal;
  logic [N_CAP-1:0][CNT_W-1:0] capVal;

  ftc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .count(count),
    .cmpVal(cmpVal), .capVal(capVal), .events(events),
    .strobe(strobe), .irqReq(irqReq)
  );

  ftc_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .capIn(capIn),
    .count(count), .cmpVal(cmpVal), .capVal(capVal),
    .waveOut(waveOut), .events(events)
  );
endmodule

// File: tb/test_ftc_timer.sv
module test_ftc_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [3:0]  capIn = '0;
  logic [3:0]  waveOut;
  logic        irqReq;
  int total = 0;
  int bad = 0;

  localparam int ACTRL = 0, ACNT = 1, ACMP = 2, ACAP = 6, AEDGE = 10, AFLAG = 11;

  always #2.5 clk = ~clk;

  ftc_timer i_ftc_timer (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .capIn(capIn),
    .waveOut(waveOut), .irqReq(irqReq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    capIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(int addr, logic [15:0] data);
    @(negedge clk);
    busWr = 1'b1;
    busAddr = 4'(addr);
    busWrData = data;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(int addr, output logic [15:0] data);
    busAddr = 4'(addr);
    #1;
    data = busRdData;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [15:0] v;
    doReset();
    busRead(ACNT, v);     check("R1 count", v, 0);
    busRead(AFLAG, v);    check("R1 flags", v, 0);
    busRead(ACAP, v);     check("R1 capture0", v, 0);
    busRead(ACMP + 3, v); check("R1 compare3", v, 0);
    check("R1 waveOut", waveOut, 0);
    check("R1 irqReq", irqReq, 0);
  endtask

  task automatic testPrescale();
    logic [15:0] v;
    doReset();
    busWrite(ACTRL, 16'h000B);
    waitCycles(47); busRead(ACNT, v); check("R2 div16 before step", v, 2);
    waitCycles(1);  busRead(ACNT, v); check("R2 div16 on step", v, 3);
    busWrite(ACTRL, 16'h0000);
    waitCycles(20); busRead(ACNT, v); check("R2 hold when stopped", v, 3);
    busWrite(ACNT, 16'h00AB);
    busRead(ACNT, v); check("R2 counter load", v, 16'h00AB);
  endtask

  task automatic testOverflow();
    logic [15:0] v;
    doReset();
    busWrite(ACNT, 16'hFFFE);
    busWrite(ACTRL, 16'h0008);
    waitCycles(3);
    busRead(ACNT, v);  check("R3 count before wrap", v, 16'hFFFF);
    busRead(AFLAG, v); check("R3 no flag before wrap", v[8], 0);
    check("R11 irq low before wrap", irqReq, 0);
    waitCycles(1);
    busRead(ACNT, v);  check("R3 count wrapped", v, 0);
    busRead(AFLAG, v); check("R3 overflow flag", v[8], 1);
    check("R11 irq high on flag", irqReq, 1);
  endtask

  task automatic testFlagClear();
    logic [15:0] f, v;
    busWrite(ACTRL, 16'h0000);
    waitCycles(2);
    busRead(AFLAG, f);
    busWrite(AFLAG, 16'h01FF);
    busRead(AFLAG, v); check("R10 ones keep flags", v, f);
    busWrite(AFLAG, 16'h00FF);
    busRead(AFLAG, v); check("R10 zero clears overflow only", v, f & 16'h00FF);
    busWrite(AFLAG, 16'h0000);
    busRead(AFLAG, v); check("R10 all cleared", v, 0);
    check("R11 irq low after clear", irqReq, 0);
  endtask

  task automatic testToggle();
    logic [15:0] v;
    doReset();
    busWrite(ACMP + 2, 16'd5);
    busWrite(ACTRL, 16'h0008);
    waitCycles(11);
    check("R6 wave2 before match", waveOut[2], 0);
    busRead(AFLAG, v); check("R4 flag2 before match", v[2], 0);
    waitCycles(1);
    check("R6 wave2 toggled", waveOut[2], 1);
    busRead(AFLAG, v); check("R4 flag2 on match", v[2], 1);
  endtask

  task automatic testClearOnMatch();
    logic [15:0] v;
    doReset();
    busWrite(ACMP, 16'd3);
    busWrite(ACTRL, 16'h0018);
    waitCycles(7);  busRead(ACNT, v); check("R5 reaches bound", v, 3);
    waitCycles(1);  busRead(ACNT, v); check("R5 cleared at bound", v, 0);
    busRead(AFLAG, v); check("R4 flag0 on clear", v[0], 1);
    waitCycles(12); busRead(ACNT, v); check("R5 period wraps", v, 2);
  endtask

  task automatic testPaired();
    doReset();
    busWrite(ACMP, 16'd2);
    busWrite(ACMP + 1, 16'd6);
    busWrite(ACTRL, 16'h0028);
    waitCycles(5); check("R7 even low before set", waveOut[0], 0);
    waitCycles(1); check("R7 even set", waveOut[0], 1);
    check("R7 odd low", waveOut[1], 0);
    waitCycles(7); check("R7 even held", waveOut[0], 1);
    waitCycles(1); check("R7 even cleared", waveOut[0], 0);
    check("R7 odd still low", waveOut[1], 0);
  endtask

  task automatic testCapture();
    logic [15:0] v;
    doReset();
    busWrite(AEDGE, 16'h00E4);
    busWrite(ACNT, 16'h1234);
    @(negedge clk); capIn[1] = 1'b1;
    waitCycles(2); busRead(AFLAG, v); check("R9 flag not yet", v[5], 0);
    waitCycles(1); busRead(AFLAG, v); check("R9 flag on third edge", v[5], 1);
    busRead(ACAP + 1, v); check("R8 rising captured", v, 16'h1234);
    busWrite(AFLAG, 16'h0000);
    busWrite(ACNT, 16'h2222);
    @(negedge clk); capIn[1] = 1'b0;
    waitCycles(5);
    busRead(ACAP + 1, v); check("R8 falling ignored on rising-only", v, 16'h1234);
    busRead(AFLAG, v);    check("R8 no flag for ignored edge", v[5], 0);
    @(negedge clk); capIn[2] = 1'b1;
    waitCycles(5); busRead(ACAP + 2, v); check("R8 rising ignored on falling-only", v, 0);
    busWrite(ACNT, 16'h3333);
    @(negedge clk); capIn[2] = 1'b0;
    waitCycles(5); busRead(ACAP + 2, v); check("R8 falling captured", v, 16'h3333);
    busWrite(ACNT, 16'h4444);
    @(negedge clk); capIn[3] = 1'b1;
    waitCycles(5); busRead(ACAP + 3, v); check("R8 both: rise", v, 16'h4444);
    busWrite(ACNT, 16'h5555);
    @(negedge clk); capIn[3] = 1'b0;
    waitCycles(5); busRead(ACAP + 3, v); check("R8 both: fall", v, 16'h5555);
    @(negedge clk); capIn[0] = 1'b1;
    waitCycles(5); @(negedge clk); capIn[0] = 1'b0;
    waitCycles(5);
    busRead(ACAP, v);  check("R8 code 00 no capture", v, 0);
    busRead(AFLAG, v); check("R8 code 00 no flag", v[4], 0);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testPrescale();
    testOverflow();
    testFlagClear();
    testToggle();
    testClearOnMatch();
    testPaired();
    testCapture();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule